// File: doc/BRIEF.md
# Transmit Enable Sequencer

This block produces three ordered enable strobes for a radio transmit path: a command strobe, a power-enable strobe and a modulation strobe. A start request brings them up one after another on consecutive clock edges. A stop request takes them down in the reverse order, with two programmable waits between the falling edges. Each wait is a 4-bit count of time units. A unit is a fixed number of input clocks, and a select bit chooses between a short unit and a long one.

An optional clear-to-send qualification can hold a start back. When the gate is enabled, an accepted start request waits in a pending flag until the clear-to-send input is high, and only then does the rising sequence begin. Requests that arrive while the sequence cannot serve them are remembered: a stop during the rising phase is served once all strobes are high, and a start during the falling phase is served after the command strobe has dropped. Register decoding and pin multiplexing sit outside this block.

Top module: `txen_sequencer`

## Requirements
- R1: After reset all three strobes (`stb_cmd_o`, `stb_pwr_o`, `stb_mod_o`) are low and no start or stop request is pending.
- R2: When a start is accepted at clock edge E, `stb_cmd_o` is high after E, `stb_pwr_o` rises at E+1 and `stb_mod_o` rises at E+2. All three then stay high until a stop is accepted.
- R3: A stop accepted at edge S, with all strobes high, drops `stb_mod_o` at S. `stb_pwr_o` drops later and `stb_cmd_o` drops last. A strobe is never high while the strobe before it in rising order is low.
- R4: `stb_pwr_o` falls at edge F2 = S + 1 + A*U, where A is `gap_t3t2_i` and U is the unit length in clocks. A = 0 gives the edge right after S.
- R5: `stb_cmd_o` falls at F2 + 1 + B*U, where B is `gap_t2t1_i`.
- R6: U is UNIT_LO_CLKS (default 20) when `slow_unit_i` is 0 and UNIT_HI_CLKS (default 40) when it is 1. Both gap fields and the unit select are captured at the edge that accepts the stop. Changes made after that edge do not affect the ongoing ramp-down.
- R7: With `cts_gate_en_i` = 1, a start request is held and `stb_cmd_o` rises at the first edge at which `cts_i` is sampled high. The normal timing follows from there.
- R8: With `cts_gate_en_i` = 0, a start request is accepted at the edge where it is sampled, whatever the level of `cts_i`.
- R9: A start request arriving during the ramp-down is latched. If the gate allows, `stb_cmd_o` rises again one edge after it fell.
- R10: A stop request arriving during the ramp-up is latched. It is served at the first edge after `stb_mod_o` rises, so `stb_mod_o` is high for exactly one cycle.
- R11: A stop request while idle, and a start request while all strobes are high, have no effect. The strobes neither move nor restart later because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; also the base of the gap unit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled each edge |
| stop_i | input | 1 | Stop request, sampled each edge |
| cts_i | input | 1 | Clear-to-send level |
| cts_gate_en_i | input | 1 | 1 makes a start wait for `cts_i` high |
| slow_unit_i | input | 1 | 0 selects the short gap unit, 1 the long one |
| gap_t3t2_i | input | GAP_W | Units between the modulation strobe falling and the power strobe falling |
| gap_t2t1_i | input | GAP_W | Units between the power strobe falling and the command strobe falling |
| stb_cmd_o | output | 1 | First strobe up, last down |
| stb_pwr_o | output | 1 | Second strobe |
| stb_mod_o | output | 1 | Last strobe up, first down |

## Verification
The main sequence runs for every pair of gap values with both unit selects, using short unit lengths. Every rising and falling edge is time-stamped and compared with its arithmetic position, so an off-by-one in the prescaler or the counter shows up separately from a wrong unit choice or swapped gap fields. Separate patterns hold a start behind a low clear-to-send, and drop the gate to show that `cts_i` is ignored. Further patterns stack requests into the opposite phase (stop while rising, start while falling) and issue requests that must be ignored, which tells a latched request apart from a lost or a spurious one. One run changes the gap fields and the unit select just after the stop, to show they were captured at that edge.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_RISE_CMD = 3'd1,
        SEQ_RISE_PWR = 3'd2,
        SEQ_HOLD     = 3'd3,
        SEQ_DROP_MOD = 3'd4,
        SEQ_DROP_PWR = 3'd5
    } seq_state_e;

endpackage

// File: rtl/txseq_prescaler.sv
module txseq_prescaler #(
    parameter int DIV_LO = 20,
    parameter int DIV_HI = 40
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    input  logic sel_i,
    output logic tick_o
);
    localparam int PW = $clog2(DIV_HI + 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_state_t;

    pre_state_t    s_d, s_q;
    logic [PW-1:0] term;

    always_comb begin
        s_d    = s_q;
        term   = sel_i ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
        tick_o = run_i && (s_q.pre == term);
        if (clear_i) begin
            s_d.pre = '0;
        end else if (run_i) begin
            s_d.pre = tick_o ? '0 : s_q.pre + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.pre <= PW'(DIV_HI - 1)); // R6

    AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (s_q.pre == '0)); // R4

endmodule

// File: rtl/txseq_gap_counter.sv
module txseq_gap_counter #(
    parameter int GAP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [GAP_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             zero_o
);
    typedef struct packed {
        logic [GAP_W-1:0] cnt;
    } gap_state_t;

    gap_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = load_val_i;
        end else if (tick_i && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - GAP_W'(1);
        end
        zero_o = (s_q.cnt == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i) |-> (s_q.cnt != '0)); // R4

    AST_LOAD_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (s_q.cnt == $past(load_val_i))); // R5

endmodule

// File: rtl/txseq_req_gate.sv
module txseq_req_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic stop_i,
    input  logic cts_i,
    input  logic cts_gate_en_i,
    input  logic idle_i,
    input  logic rising_i,
    input  logic hold_i,
    input  logic falling_i,
    output logic go_o,
    output logic halt_o
);
    typedef struct packed {
        logic start_pend;
        logic stop_pend;
    } gate_state_t;

    gate_state_t s_d, s_q;
    logic        start_req;
    logic        stop_req;
    logic        cts_ok;

    always_comb begin
        s_d       = s_q;
        start_req = start_i || s_q.start_pend;
        stop_req  = stop_i || s_q.stop_pend;
        cts_ok    = !cts_gate_en_i || cts_i;
        go_o      = idle_i && start_req && cts_ok;
        halt_o    = hold_i && stop_req;

        if (go_o) begin
            s_d.start_pend = 1'b0;
        end else if (start_i && (idle_i || falling_i)) begin
            s_d.start_pend = 1'b1;
        end

        if (halt_o) begin
            s_d.stop_pend = 1'b0;
        end else if (stop_i && rising_i) begin
            s_d.stop_pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_START_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_o |=> !s_q.start_pend); // R9

    AST_STOP_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> !s_q.stop_pend); // R10

    AST_STOP_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_i |-> !s_q.stop_pend); // R11

endmodule

// File: rtl/txen_sequencer.sv
module txen_sequencer
    import txseq_pkg::*;
#(
    parameter int GAP_W        = 4,
    parameter int UNIT_LO_CLKS = 20,
    parameter int UNIT_HI_CLKS = 40
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             cts_i,
    input  logic             cts_gate_en_i,
    input  logic             slow_unit_i,
    input  logic [GAP_W-1:0] gap_t3t2_i,
    input  logic [GAP_W-1:0] gap_t2t1_i,
    output logic             stb_cmd_o,
    output logic             stb_pwr_o,
    output logic             stb_mod_o
);
    typedef struct packed {
        seq_state_e       st;
        logic             cmd;
        logic             pwr;
        logic             mod;
        logic             slow;
        logic [GAP_W-1:0] gap_b;
    } seq_reg_t;

    seq_reg_t         s_d, s_q;
    logic             go;
    logic             halt;
    logic             tick;
    logic             gap_zero;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             gap_run;
    logic             in_idle;
    logic             in_rise;
    logic             in_hold;
    logic             in_fall;

    always_comb begin
        in_idle = (s_q.st == SEQ_IDLE);
        in_rise = (s_q.st == SEQ_RISE_CMD) || (s_q.st == SEQ_RISE_PWR);
        in_hold = (s_q.st == SEQ_HOLD);
        in_fall = (s_q.st == SEQ_DROP_MOD) || (s_q.st == SEQ_DROP_PWR);
    end

    txseq_req_gate u_gate (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_i       (start_i),
        .stop_i        (stop_i),
        .cts_i         (cts_i),
        .cts_gate_en_i (cts_gate_en_i),
        .idle_i        (in_idle),
        .rising_i      (in_rise),
        .hold_i        (in_hold),
        .falling_i     (in_fall),
        .go_o          (go),
        .halt_o        (halt)
    );

    always_comb begin
        gap_load = halt || ((s_q.st == SEQ_DROP_MOD) && gap_zero);
        gap_val  = halt ? gap_t3t2_i : s_q.gap_b;
        gap_run  = in_fall && !gap_zero;
    end

    txseq_prescaler #(
        .DIV_LO (UNIT_LO_CLKS),
        .DIV_HI (UNIT_HI_CLKS)
    ) u_prescale (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (gap_load),
        .run_i   (gap_run),
        .sel_i   (s_q.slow),
        .tick_o  (tick)
    );

    txseq_gap_counter #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (gap_load),
        .load_val_i (gap_val),
        .tick_i     (tick),
        .zero_o     (gap_zero)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: begin
                if (go) begin
                    s_d.st  = SEQ_RISE_CMD;
                    s_d.cmd = 1'b1;
                end
            end
            SEQ_RISE_CMD: begin
                s_d.st  = SEQ_RISE_PWR;
                s_d.pwr = 1'b1;
            end
            SEQ_RISE_PWR: begin
                s_d.st  = SEQ_HOLD;
                s_d.mod = 1'b1;
            end
            SEQ_HOLD: begin
                if (halt) begin
                    s_d.st    = SEQ_DROP_MOD;
                    s_d.mod   = 1'b0;
                    s_d.slow  = slow_unit_i;
                    s_d.gap_b = gap_t2t1_i;
                end
            end
            SEQ_DROP_MOD: begin
                if (gap_zero) begin
                    s_d.st  = SEQ_DROP_PWR;
                    s_d.pwr = 1'b0;
                end
            end
            SEQ_DROP_PWR: begin
                if (gap_zero) begin
                    s_d.st  = SEQ_IDLE;
                    s_d.cmd = 1'b0;
                end
            end
            default: begin
                s_d.st  = SEQ_IDLE;
                s_d.cmd = 1'b0;
                s_d.pwr = 1'b0;
                s_d.mod = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: SEQ_IDLE, cmd: 1'b0, pwr: 1'b0, mod: 1'b0,
                     slow: 1'b0, gap_b: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign stb_cmd_o = s_q.cmd;
    assign stb_pwr_o = s_q.pwr;
    assign stb_mod_o = s_q.mod;

    AST_MOD_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_mod_o |-> stb_pwr_o); // R3

    AST_PWR_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_pwr_o |-> stb_cmd_o); // R3

    AST_PWR_RISE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stb_pwr_o) |-> $past(stb_cmd_o)); // R2

    AST_CMD_FALL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(stb_cmd_o) |-> !$past(stb_pwr_o)); // R5

    AST_CTS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(stb_cmd_o) && $past(cts_gate_en_i)) |-> $past(cts_i)); // R7

endmodule

// File: tb/txen_sequencer_bench.sv
module txen_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GW         = 4;
    localparam int LO         = 3;
    localparam int HI         = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start, stop, cts, cts_en, slow;
    logic [GW-1:0] ga, gb;
    logic          cmd, pwr, mod;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int r_cmd = -1, r_pwr = -1, r_mod = -1;
    int f_cmd = -1, f_pwr = -1, f_mod = -1;
    logic p_cmd = 1'b0, p_pwr = 1'b0, p_mod = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txen_sequencer #(
        .GAP_W        (GW),
        .UNIT_LO_CLKS (LO),
        .UNIT_HI_CLKS (HI)
    ) u_txen_sequencer (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .stop_i        (stop),
        .cts_i         (cts),
        .cts_gate_en_i (cts_en),
        .slow_unit_i   (slow),
        .gap_t3t2_i    (ga),
        .gap_t2t1_i    (gb),
        .stb_cmd_o     (cmd),
        .stb_pwr_o     (pwr),
        .stb_mod_o     (mod)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        if (cmd && !p_cmd) r_cmd = cyc;
        if (!cmd && p_cmd) f_cmd = cyc;
        if (pwr && !p_pwr) r_pwr = cyc;
        if (!pwr && p_pwr) f_pwr = cyc;
        if (mod && !p_mod) r_mod = cyc;
        if (!mod && p_mod) f_mod = cyc;
        p_cmd = cmd;
        p_pwr = pwr;
        p_mod = mod;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(output int e);
        e = cyc + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_stop(output int s);
        s = cyc + 1;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic wait_cmd_low();
        for (int k = 0; k < 400 && cmd; k++) @(negedge clk);
    endtask

    task automatic run_seq(input int a, input int b, input bit sl);
        int e, s, u, e_pwr, e_cmd;
        string tg;
        u = sl ? HI : LO;
        ga = GW'(a);
        gb = GW'(b);
        slow = sl;
        pulse_start(e);
        idle(3);
        chk("R2 cmd rise", r_cmd, e);
        chk("R2 pwr rise", r_pwr, e + 1);
        chk("R2 mod rise", r_mod, e + 2);
        pulse_stop(s);
        wait_cmd_low();
        idle(1);
        e_pwr = s + 1 + a * u;
        e_cmd = e_pwr + 1 + b * u;
        tg = sl ? "R6 long" : "R6 short";
        chk("R3 mod fall", f_mod, s);
        chk($sformatf("R4 %s a=%0d b=%0d", tg, a, b), f_pwr, e_pwr);
        chk($sformatf("R5 %s a=%0d b=%0d", tg, a, b), f_cmd, e_cmd);
    endtask

    initial begin
        int e, s, d, e_pwr;
        rst_n  = 1'b0;
        start  = 1'b0;
        stop   = 1'b0;
        cts    = 1'b0;
        cts_en = 1'b0;
        slow   = 1'b0;
        ga     = '0;
        gb     = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1 cmd reset", int'(cmd), 0);
        chk("R1 pwr reset", int'(pwr), 0);
        chk("R1 mod reset", int'(mod), 0);

        // R4 R5 R6: every gap pair under both unit lengths
        for (int sl = 0; sl < 2; sl++)
            for (int a = 0; a < (1 << GW); a++)
                for (int b = 0; b < (1 << GW); b++)
                    run_seq(a, b, sl[0]);

        // R8: gate off, cts low
        cts_en = 1'b0;
        cts = 1'b0;
        ga = '0;
        gb = '0;
        slow = 1'b0;
        pulse_start(e);
        idle(2);
        chk("R8 start ignores cts", r_cmd, e);
        pulse_stop(s);
        wait_cmd_low();
        idle(2);

        // R7: gate on, cts low then high
        cts_en = 1'b1;
        pulse_start(e);
        idle(6);
        chk("R7 held while cts low", int'(cmd), 0);
        d = cyc + 1;
        cts = 1'b1;
        idle(3);
        chk("R7 rise on cts", r_cmd, d);
        chk("R7 mod after cts", r_mod, d + 2);
        pulse_stop(s);
        wait_cmd_low();
        idle(2);
        pulse_start(e);
        idle(3);
        chk("R7 cts already high", r_cmd, e);
        pulse_stop(s);
        wait_cmd_low();
        idle(2);
        cts_en = 1'b0;
        cts = 1'b0;

        // R9: start during ramp-down
        ga = GW'(2);
        gb = GW'(3);
        pulse_start(e);
        idle(3);
        pulse_stop(s);
        idle(2);
        pulse_start(e);
        wait_cmd_low();
        idle(3);
        chk("R9 restart after fall", r_cmd, f_cmd + 1);
        chk("R9 fall timing", f_cmd, s + 1 + 2 * LO + 1 + 3 * LO);
        idle(2);
        chk("R9 fully up again", int'(mod), 1);
        ga = '0;
        gb = '0;
        pulse_stop(s);
        wait_cmd_low();
        idle(2);

        // R10: stop during ramp-up
        pulse_start(e);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        idle(4);
        chk("R10 mod rise", r_mod, e + 2);
        chk("R10 mod fall", f_mod, e + 3);
        wait_cmd_low();
        idle(1);
        chk("R10 cmd fall", f_cmd, e + 5);
        idle(2);

        // R11: stop while idle, start while fully up
        pulse_stop(s);
        idle(4);
        chk("R11 idle stop cmd", int'(cmd), 0);
        chk("R11 idle stop mod", int'(mod), 0);
        pulse_start(e);
        idle(8);
        chk("R11 stop not latched", int'(mod), 1);
        pulse_start(d);
        idle(2);
        pulse_stop(s);
        wait_cmd_low();
        idle(6);
        chk("R11 start while up ignored", int'(cmd), 0);
        chk("R11 start while up no rise", r_cmd, e);

        // R6: fields captured at the stop edge
        ga = GW'(4);
        gb = GW'(2);
        slow = 1'b1;
        pulse_start(e);
        idle(3);
        pulse_stop(s);
        ga = '0;
        gb = '0;
        slow = 1'b0;
        wait_cmd_low();
        idle(1);
        e_pwr = s + 1 + 4 * HI;
        chk("R6 capture pwr", f_pwr, e_pwr);
        chk("R6 capture cmd", f_cmd, e_pwr + 1 + 2 * HI);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule